// File: doc/BRIEF.md
# I2C Sequential Read Byte Sequencer

This block is the receive half of an I2C master that reads a run of consecutive bytes from a memory device within a single bus transaction. Another block has already sent the start condition, the device address and any memory address. When the host gives a start pulse together with a byte count, this engine clocks SCL, shifts in each byte MSB first, acknowledges every byte but the last, sends a negative acknowledge on the last byte so that the device lets go of SDA, and then ends the transaction with a stop condition.

Both bus lines are open-drain. They are modelled as output enables: when an enable is 1 the line is pulled low, and a released line reads back as 1. The SCL low time and high time are set by two separate cycle counts, so the same engine can meet standard-mode or fast-mode minimums from any system clock. Each received byte appears on a data output together with a one-cycle valid strobe. A busy flag covers the whole transaction and a done pulse marks its end.

Top module: `i2c_seq_reader`

## Requirements
- R1: Each data bit is sampled from `sda_in` in the cycle whose phase count equals `floor(thigh/2)` (0-based) within the SCL high phase, MSB first. One cycle after the eighth bit is sampled, `rx_valid` is 1 for exactly one cycle and `rx_data` holds the byte.
- R2: On every byte except the last, `sda_oe` is 1 for the whole low phase and the whole high phase of the ninth clock (acknowledge). It is 0 during the eight data clocks.
- R3: On the last requested byte, `sda_oe` is 0 during the ninth clock (negative acknowledge).
- R4: After the last ninth clock there is a stop sequence. First SCL is low for `tlow` cycles with `sda_oe`=1. Then SCL is released for `thigh` cycles with `sda_oe` still 1. Then `sda_oe` goes to 0 while SCL stays released, and both lines stay released for `thigh` cycles. SDA never starts being pulled low while SCL is released.
- R5: `busy` is 1 from the cycle after an accepted start until the end of the stop sequence. In the next cycle `done` is 1 for one cycle with `busy` 0, and then the block is idle.
- R6: Each bit clock is `tlow` cycles with `scl_oe`=1 followed by `thigh` cycles with `scl_oe`=0. Both counts are captured at start, and a count below 2 is treated as 2.
- R7: A start pulse is ignored while `busy` is 1 or when `byte_count` is 0. Any count from 1 to 2^CNT_W-1 is read without a restart.
- R8: After reset and whenever idle, `scl_oe`, `sda_oe`, `busy`, `done` and `rx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a read run |
| byte_count | input | CNT_W | Number of bytes to read |
| thigh | input | TW | SCL high time in clock cycles |
| tlow | input | TW | SCL low time in clock cycles |
| sda_in | input | 1 | SDA line level as read back |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse after the stop completes |

## Verification
The assertions assume that the environment drives SDA only through a wired-AND with the engine's own pull-down, and that the bus starts idle with no other master present. They check only the edge ordering of the two enables and the shape of the busy, done and valid strobes. The stimulus keeps to these assumptions. The modelled device drives its bit only during data clocks and releases SDA during every acknowledge slot and during the stop. Start pulses are issued only from idle, except for the deliberate ignored-start cases.

// File: rtl/i2c_seq_pkg.sv
// Shared types for the sequential read sequencer.
package i2c_seq_pkg;
    // Sequencer states: bit clocking, the three stop phases, and the completion cycle.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_SP_LOW,
        ST_SP_HIGH,
        ST_SP_FREE,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/i2c_seq_phase_timer.sv
// Phase timer: counts the cycles spent in one SCL phase.
// Assumes len >= 2. The owner asserts restart on the last cycle of a phase
// (or while idle), so that every phase begins with count 0.
module i2c_seq_phase_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [TW-1:0] len,
    output logic [TW-1:0] cnt,
    output logic          last
);
    // Cycle counter for the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    // Final cycle of the phase.
    assign last = (cnt == len - 1'b1);
endmodule

// File: rtl/i2c_seq_rx_shift.sv
// Receive shifter: assembles a byte MSB first from sampled bits and pulses
// valid one cycle after the eighth sample. Assumes sample is asserted only
// for data bits.
module i2c_seq_rx_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample,
    input  logic       bit_in,
    input  logic       final_bit,
    output logic       rx_valid,
    output logic [7:0] rx_data
);
    logic [7:0] sh;

    // Shift register, output byte register and valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh       <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (sample) begin
                sh <= {sh[6:0], bit_in};
                if (final_bit) begin
                    rx_data  <= {sh[6:0], bit_in};
                    rx_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/i2c_seq_reader.sv
// Sequential read sequencer: clocks SCL for byte_count bytes, acknowledges
// all but the last byte, sends a negative acknowledge on the last byte, then
// generates a stop. Assumes the start condition and the address phase were
// already issued by another block, with SCL left low-ready.
module i2c_seq_reader
    import i2c_seq_pkg::*;
#(
    parameter int CNT_W = 14,
    parameter int TW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_count,
    input  logic [TW-1:0]    thigh,
    input  logic [TW-1:0]    tlow,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             busy,
    output logic             done
);
    localparam logic [TW-1:0] MIN_PH = TW'(2);
    localparam logic [3:0]    ACK_IX = 4'd8;

    seq_state_t       state;
    logic [3:0]       bit_ix;
    logic [CNT_W-1:0] left;
    logic [TW-1:0]    th_q, tl_q, ph_len, ph_cnt;
    logic             ph_last, sample, is_low_ph;

    // Clamp a phase length to the minimum the timer supports.
    function automatic logic [TW-1:0] clamp_len(input logic [TW-1:0] v);
        return (v < MIN_PH) ? MIN_PH : v;
    endfunction

    // Pick the length of the current phase.
    assign is_low_ph = (state == ST_LOW) || (state == ST_SP_LOW);
    assign ph_len    = is_low_ph ? tl_q : th_q;

    i2c_seq_phase_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart ((state == ST_IDLE) || (state == ST_DONE) || ph_last),
        .len     (ph_len),
        .cnt     (ph_cnt),
        .last    (ph_last)
    );

    // Sample a data bit in the middle of the high phase.
    assign sample = (state == ST_HIGH) && (bit_ix < ACK_IX) && (ph_cnt == (th_q >> 1));

    i2c_seq_rx_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (sample),
        .bit_in    (sda_in),
        .final_bit (bit_ix == 4'd7),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data)
    );

    // Main sequencer: bit and byte progress, stop phases and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            bit_ix <= '0;
            left   <= '0;
            th_q   <= MIN_PH;
            tl_q   <= MIN_PH;
        end else begin
            case (state)
                ST_IDLE: if (start && (byte_count != '0)) begin
                    state  <= ST_LOW;
                    bit_ix <= '0;
                    left   <= byte_count;
                    th_q   <= clamp_len(thigh);
                    tl_q   <= clamp_len(tlow);
                end
                ST_LOW: if (ph_last) state <= ST_HIGH;
                ST_HIGH: if (ph_last) begin
                    if (bit_ix == ACK_IX) begin
                        bit_ix <= '0;
                        if (left == CNT_W'(1)) state <= ST_SP_LOW;
                        else begin
                            left  <= left - 1'b1;
                            state <= ST_LOW;
                        end
                    end else begin
                        bit_ix <= bit_ix + 1'b1;
                        state  <= ST_LOW;
                    end
                end
                ST_SP_LOW:  if (ph_last) state <= ST_SP_HIGH;
                ST_SP_HIGH: if (ph_last) state <= ST_SP_FREE;
                ST_SP_FREE: if (ph_last) state <= ST_DONE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // Line enables and status derived from the registered state.
    assign scl_oe = is_low_ph;
    assign sda_oe = (((state == ST_LOW) || (state == ST_HIGH)) && (bit_ix == ACK_IX) && (left != CNT_W'(1)))
                  || (state == ST_SP_LOW) || (state == ST_SP_HIGH);
    assign busy   = (state != ST_IDLE) && (state != ST_DONE);
    assign done   = (state == ST_DONE);
endmodule

// File: rtl/i2c_seq_reader_chk.sv
// Checker for the sequential read sequencer: bus edge ordering and strobe shape.
module i2c_seq_reader_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_oe,
    input logic sda_oe,
    input logic rx_valid,
    input logic busy,
    input logic done
);
    // R1: the byte strobe never lasts more than one cycle.
    a_r1_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R4: SDA is never pulled low while SCL stays released (no false start).
    a_r4_no_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && $past(!scl_oe)) |-> !$rose(sda_oe));

    // R4: SDA is released under a released SCL only if SCL was already released.
    a_r4_stop_under_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe) && !scl_oe) |-> $past(!scl_oe));

    // R5: done comes with busy low, right after a busy cycle.
    a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R8: both lines are released whenever the block is not busy.
    a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));
endmodule

bind i2c_seq_reader i2c_seq_reader_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .rx_valid (rx_valid),
    .busy     (busy),
    .done     (done)
);

// File: tb/tb_i2c_seq_reader.sv
// Bench: a behavioural per-cycle schedule of expected outputs built from the
// requirements, compared against the design on every falling clock edge.
module tb_i2c_seq_reader;
    localparam int CNT_W = 14;
    localparam int TW    = 8;

    typedef struct packed {
        logic [7:0] data;
        logic       valid;
        logic       slave;
        logic       scl;
        logic       sda;
        logic       busy;
        logic       done;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] byte_count = '0;
    logic [TW-1:0]    thigh = TW'(4);
    logic [TW-1:0]    tlow = TW'(5);
    logic             slave_bit = 1'b1;
    wire              sda_in;
    wire              scl_oe, sda_oe, rx_valid, busy, done;
    wire [7:0]        rx_data;

    int   total = 0;
    int   bad = 0;
    int   cycles = 0;
    bit   run_cmp = 1'b0;
    exp_t q[$];

    assign sda_in = slave_bit & ~sda_oe;

    i2c_seq_reader #(.CNT_W(CNT_W), .TW(TW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
        .thigh(thigh), .tlow(tlow), .sda_in(sda_in), .scl_oe(scl_oe),
        .sda_oe(sda_oe), .rx_valid(rx_valid), .rx_data(rx_data),
        .busy(busy), .done(done)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] pattern(input int seed, input int i);
        return 8'((seed * 37 + i * 91 + 5) & 255);
    endfunction

    function automatic exp_t ent(input logic scl, input logic sda, input logic busy_v, input logic slv);
        exp_t e;
        e = '0;
        e.scl = scl; e.sda = sda; e.busy = busy_v; e.slave = slv;
        return e;
    endfunction

    // Append the expected schedule of one read run.
    task automatic plan(input int n, input int th_in, input int tl_in, input int seed);
        int th, tl, mark;
        logic [7:0] b;
        exp_t e;
        th = (th_in < 2) ? 2 : th_in;
        tl = (tl_in < 2) ? 2 : tl_in;
        for (int i = 0; i < n; i++) begin
            b = pattern(seed, i);
            mark = 0;
            for (int k = 0; k < 9; k++) begin
                logic s, ack;
                s   = (k < 8) ? b[7-k] : 1'b1;
                ack = (k == 8) && (i != n - 1);
                for (int c = 0; c < tl; c++) q.push_back(ent(1'b1, ack, 1'b1, s));
                if (k == 7) mark = q.size() + th / 2 + 1;
                for (int c = 0; c < th; c++) q.push_back(ent(1'b0, ack, 1'b1, s));
            end
            e = q[mark];
            e.valid = 1'b1;
            e.data  = b;
            q[mark] = e;
        end
        for (int c = 0; c < tl; c++) q.push_back(ent(1'b1, 1'b1, 1'b1, 1'b1));
        for (int c = 0; c < th; c++) q.push_back(ent(1'b0, 1'b1, 1'b1, 1'b1));
        for (int c = 0; c < th; c++) q.push_back(ent(1'b0, 1'b0, 1'b1, 1'b1));
        e = ent(1'b0, 1'b0, 1'b0, 1'b1);
        e.done = 1'b1;
        q.push_back(e);
    endtask

    // Per-cycle comparison against the schedule (idle expected when it is empty).
    always @(negedge clk) begin
        if (run_cmp) begin
            exp_t e;
            string rq;
            e = (q.size() != 0) ? q.pop_front() : ent(1'b0, 1'b0, 1'b0, 1'b1);
            rq = (e.busy || e.done) ? "R2/R3/R4" : "R8";
            slave_bit = e.slave;
            check(scl_oe == e.scl, (e.busy || e.done) ? "R6" : "R8", "scl_oe", int'(scl_oe), int'(e.scl));
            check(sda_oe == e.sda, rq, "sda_oe", int'(sda_oe), int'(e.sda));
            check(busy == e.busy, "R5", "busy", int'(busy), int'(e.busy));
            check(done == e.done, "R5", "done", int'(done), int'(e.done));
            check(rx_valid == e.valid, "R1", "rx_valid", int'(rx_valid), int'(e.valid));
            if (e.valid) check(rx_data == e.data, "R1", "rx_data", int'(rx_data), int'(e.data));
        end
    end

    // Launch a run: start is seen by the design at the next rising edge.
    task automatic launch(input int n, input int th, input int tl, input int seed, input bit expect_run);
        @(posedge clk); #1;
        start = 1'b1; byte_count = CNT_W'(n); thigh = TW'(th); tlow = TW'(tl);
        @(posedge clk); #1;
        start = 1'b0;
        if (expect_run) plan(n, th, tl, seed);
    endtask

    task automatic drain();
        while (q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            check(1'b0, "R5", "watchdog", cycles, 100000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check(!scl_oe && !sda_oe && !busy && !done && !rx_valid, "R8", "reset outputs",
              int'({scl_oe, sda_oe, busy, done, rx_valid}), 0);
        run_cmp = 1'b1;

        // Single byte: NACK straight away, then stop (R3, R4).
        launch(1, 4, 5, 1, 1'b1);
        drain();

        // Three bytes: ACK on first two (R2), bytes assembled (R1).
        launch(3, 6, 7, 2, 1'b1);
        drain();

        // Lengths below the minimum treated as 2 (R6).
        launch(2, 1, 0, 3, 1'b1);
        drain();

        // R7: zero count ignored.
        launch(0, 4, 4, 4, 1'b0);
        @(negedge clk);
        check(busy == 1'b0, "R7", "busy after zero count", int'(busy), 0);

        // R7: start while busy ignored; new timing inputs do not disturb the run.
        launch(2, 3, 4, 5, 1'b1);
        repeat (10) @(posedge clk);
        launch(5, 9, 9, 6, 1'b0);
        drain();

        // Odd high time, longer run.
        launch(4, 5, 3, 7, 1'b1);
        drain();

        finish_run();
    end
endmodule